// File: doc/BRIEF.md
# Filtered GPIO Interrupt Front End

This block sits between a set of interrupt-capable GPIO lines and an upstream interrupt controller. Each line has three configuration bits: an enable, a mode and a filter enable. A fourth setting, the filter period, is a single value that every line shares. In level mode an enabled line is synchronised and handed straight through, so the upstream controller can apply its own level or edge sense. In both-edge mode the synchronised line passes through a stability filter first. Every accepted change of the filtered level, whether rising or falling, is sent upstream as a one-cycle low pulse on a line that otherwise rests high. The upstream controller therefore only needs to be set up for falling edges.

Both-edge detection works only while the line's filter is enabled. If the filter is off, a both-edge line produces no events. The filter is on the interrupt path only. A small word-addressed configuration port writes the four settings and reads them back.

Top module: `gpio_irq_front`

## Requirements
- R1: After a synchronous reset, the enable, mode and filter-enable words read 0, the filter period reads 0xFF, and every irq_out bit is 0.
- R2: The configuration word is chosen by cfg_addr: 0 is enable, 1 is mode (1 = both-edge), 2 is filter enable, and 3 is the filter period in bits 7:0. Bit i of words 0 to 2 belongs to line i. cfg_rdata shows the addressed word one clock later, and unimplemented upper bits read 0.
- R3: A line whose enable bit is 0 holds irq_out at its idle level whatever its input does. The idle level is 0 in level mode and 1 in both-edge mode.
- R4: An enabled level-mode line copies irq_raw to irq_out. A value present at a clock edge appears on irq_out two clock cycles after that edge.
- R5: In both-edge mode with the filter enabled, the filtered level takes a new value only after the synchronised input has differed from it for period+1 consecutive cycles. Each accepted change, rising or falling, drives irq_out low for exactly one cycle.
- R6: An input excursion in both-edge mode that is shorter than the filter threshold produces no pulse.
- R7: In both-edge mode with the filter disabled, irq_out stays high and no events are produced.
- R8: The single period value sets the threshold of every line at once. Rewriting it changes acceptance on all lines.
- R9: The filter has no effect on a level-mode line. Setting its filter bit leaves even a one-cycle input pulse visible on irq_out with the R4 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered readback of the selected word |
| irq_raw | input | 24 | Asynchronous interrupt inputs from the GPIO pads |
| irq_out | output | 24 | Registered outputs toward the upstream controller |

## Verification
A rising step held for twelve cycles and then released shows that both edges of the input become separate low pulses. A three-cycle excursion measured against a period of 3 checks that the threshold is counted as period+1 cycles and is not off by one. The same pulse trains are then run on a level-mode line with its filter bit set, on a both-edge line with the filter off, and on masked lines. These runs separate the pass-through, no-event and idle behaviours. A long sparse random toggle pattern is also run while the shared period steps through values including 0, and a reference model compares the output every cycle. Changing the period between two identical pulse trains on two distant lines shows that the threshold is shared.

// File: rtl/gif_pkg.sv
package gif_pkg;

  typedef enum logic [1:0] {
    CFG_ENABLE = 2'd0,
    CFG_MODE   = 2'd1,
    CFG_FILT   = 2'd2,
    CFG_PERIOD = 2'd3
  } cfg_sel_e;

  localparam int CFG_ADDR_W = 2;

endpackage

// File: rtl/gif_regs.sv
module gif_regs
  import gif_pkg::*;
#(
  parameter int NUM_LINES   = 24,
  parameter int PERIOD_W    = 8,
  parameter int DATA_W      = 32,
  parameter int PERIOD_INIT = 255
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [CFG_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_LINES-1:0]  en_q,
  output logic [NUM_LINES-1:0]  mode_q,
  output logic [NUM_LINES-1:0]  fen_q,
  output logic [PERIOD_W-1:0]   period_q
);

  cfg_sel_e sel;
  logic     unused_wdata_hi;

  assign sel             = cfg_sel_e'(addr);
  assign unused_wdata_hi = ^wdata[DATA_W-1:NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= '0;
      mode_q   <= '0;
      fen_q    <= '0;
      period_q <= PERIOD_W'(PERIOD_INIT);
      rdata    <= '0;
    end else begin
      unique case (sel)
        CFG_ENABLE: rdata <= DATA_W'(en_q);
        CFG_MODE:   rdata <= DATA_W'(mode_q);
        CFG_FILT:   rdata <= DATA_W'(fen_q);
        CFG_PERIOD: rdata <= DATA_W'(period_q);
        default:    rdata <= '0;
      endcase
      if (we) begin
        unique case (sel)
          CFG_ENABLE: en_q     <= wdata[NUM_LINES-1:0];
          CFG_MODE:   mode_q   <= wdata[NUM_LINES-1:0];
          CFG_FILT:   fen_q    <= wdata[NUM_LINES-1:0];
          CFG_PERIOD: period_q <= wdata[PERIOD_W-1:0];
          default:    ;
        endcase
      end
    end
  end

endmodule

// File: rtl/gif_sync.sv
module gif_sync #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end

endmodule

// File: rtl/gif_line.sv
module gif_line #(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                mode,
  input  logic                fen,
  input  logic [PERIOD_W-1:0] period,
  input  logic                lvl,
  output logic                filt,
  output logic                irq
);

  logic [PERIOD_W-1:0] cnt;
  logic                differs;
  logic                settled;
  logic                event_now;

  assign differs   = (lvl != filt);
  assign settled   = (cnt >= period);
  assign event_now = mode & fen & differs & settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt <= 1'b0;
      cnt  <= '0;
      irq  <= 1'b0;
    end else begin
      if (en) begin
        irq <= mode ? ~event_now : lvl;
      end else begin
        irq <= mode;
      end

      if (!fen) begin
        filt <= lvl;
        cnt  <= '0;
      end else if (!differs) begin
        cnt <= '0;
      end else if (settled) begin
        filt <= lvl;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/gpio_irq_front.sv
module gpio_irq_front
  import gif_pkg::*;
#(
  parameter int NUM_LINES   = 24,
  parameter int PERIOD_W    = 8,
  parameter int DATA_W      = 32,
  parameter int PERIOD_INIT = 255
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [CFG_ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0]     cfg_wdata,
  output logic [DATA_W-1:0]     cfg_rdata,
  input  logic [NUM_LINES-1:0]  irq_raw,
  output logic [NUM_LINES-1:0]  irq_out
);

  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] mode_q;
  logic [NUM_LINES-1:0] fen_q;
  logic [PERIOD_W-1:0]  period_q;
  logic [NUM_LINES-1:0] sync_lvl;
  logic [NUM_LINES-1:0] filt_lvl;

  gif_regs #(
    .NUM_LINES  (NUM_LINES),
    .PERIOD_W   (PERIOD_W),
    .DATA_W     (DATA_W),
    .PERIOD_INIT(PERIOD_INIT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .en_q    (en_q),
    .mode_q  (mode_q),
    .fen_q   (fen_q),
    .period_q(period_q)
  );

  gif_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (irq_raw),
    .q  (sync_lvl)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gif_line #(.PERIOD_W(PERIOD_W)) u_line (
      .clk   (clk),
      .rst   (rst),
      .en    (en_q[i]),
      .mode  (mode_q[i]),
      .fen   (fen_q[i]),
      .period(period_q),
      .lvl   (sync_lvl[i]),
      .filt  (filt_lvl[i]),
      .irq   (irq_out[i])
    );
  end

endmodule

// File: rtl/gif_checker.sv
module gif_checker #(
  parameter int NUM_LINES   = 24,
  parameter int PERIOD_W    = 8,
  parameter int PERIOD_INIT = 255
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] mode_q,
  input logic [NUM_LINES-1:0] fen_q,
  input logic [PERIOD_W-1:0]  period_q,
  input logic [NUM_LINES-1:0] sync_lvl,
  input logic [NUM_LINES-1:0] filt_lvl,
  input logic [NUM_LINES-1:0] irq_out
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (en_q == '0 && mode_q == '0 && fen_q == '0 &&
             period_q == PERIOD_W'(PERIOD_INIT) && irq_out == '0));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    a_r3_masked_idle: assert property (@(posedge clk) disable iff (rst)
      !en_q[i] |=> irq_out[i] == $past(mode_q[i]));

    a_r4_level_follow: assert property (@(posedge clk) disable iff (rst)
      (en_q[i] && !mode_q[i]) |=> irq_out[i] == $past(sync_lvl[i]));

    a_r7_no_unfiltered_event: assert property (@(posedge clk) disable iff (rst)
      (mode_q[i] && !fen_q[i]) |=> irq_out[i]);

    a_r5_change_pulses: assert property (@(posedge clk) disable iff (rst)
      ($past(en_q[i] && mode_q[i] && fen_q[i]) && filt_lvl[i] != $past(filt_lvl[i]))
        |-> !irq_out[i]);
  end

endmodule

bind gpio_irq_front gif_checker #(
  .NUM_LINES  (NUM_LINES),
  .PERIOD_W   (PERIOD_W),
  .PERIOD_INIT(PERIOD_INIT)
) u_gif_checker (
  .clk     (clk),
  .rst     (rst),
  .en_q    (en_q),
  .mode_q  (mode_q),
  .fen_q   (fen_q),
  .period_q(period_q),
  .sync_lvl(sync_lvl),
  .filt_lvl(filt_lvl),
  .irq_out (irq_out)
);

// File: tb/tb_gpio_irq_front.sv
`timescale 1ns/1ps
module tb_gpio_irq_front;
  localparam int NL = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic [NL-1:0] irq_raw = '0;
  logic [NL-1:0] irq_out;

  always #2.5 clk = ~clk;

  gpio_irq_front dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_raw(irq_raw), .irq_out(irq_out)
  );

  int    checks = 0;
  int    errors = 0;
  string req = "R1";
  bit    live = 1'b0;
  bit    done = 1'b0;
  int    lows[NL];
  int    highs[NL];

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", r, $time, act, exp);
    end
  endtask

  // behavioural reference model
  logic [NL-1:0] m_s1, m_s2, m_f, m_out, m_en, m_mode, m_fen;
  int            m_cnt[NL];
  int            m_per;
  logic [DW-1:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_f = '0; m_out = '0;
      m_en = '0; m_mode = '0; m_fen = '0; m_per = 255; m_rd = '0;
      for (int i = 0; i < NL; i++) m_cnt[i] = 0;
    end else begin
      case (cfg_addr)
        2'd0: m_rd = DW'(m_en);
        2'd1: m_rd = DW'(m_mode);
        2'd2: m_rd = DW'(m_fen);
        default: m_rd = DW'(m_per);
      endcase
      for (int i = 0; i < NL; i++) begin
        bit ev;
        ev = m_mode[i] && m_fen[i] && (m_s2[i] != m_f[i]) && (m_cnt[i] >= m_per);
        if (!m_en[i]) m_out[i] = m_mode[i];
        else if (m_mode[i]) m_out[i] = !ev;
        else m_out[i] = m_s2[i];
        if (!m_fen[i]) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
        else if (m_s2[i] == m_f[i]) m_cnt[i] = 0;
        else if (m_cnt[i] >= m_per) begin m_f[i] = m_s2[i]; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end
      m_s2 = m_s1;
      m_s1 = irq_raw;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: m_en = cfg_wdata[NL-1:0];
          2'd1: m_mode = cfg_wdata[NL-1:0];
          2'd2: m_fen = cfg_wdata[NL-1:0];
          default: m_per = int'(cfg_wdata[7:0]);
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk(irq_out === m_out, req, DW'(irq_out), DW'(m_out));
      chk(cfg_rdata === m_rd, "R2", cfg_rdata, m_rd);
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      for (int i = 0; i < NL; i++) begin
        if (irq_out[i]) highs[i]++;
        else lows[i]++;
      end
    end
  endtask

  task automatic clr();
    for (int i = 0; i < NL; i++) begin lows[i] = 0; highs[i] = 0; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string r);
    cfg_addr = a;
    step(1);
    chk(cfg_rdata === exp, r, cfg_rdata, exp);
  endtask

  initial begin
    step(4);
    rst = 1'b0;
    live = 1'b1;
    step(1);
    // R1: reset values
    chk(irq_out === '0, "R1", DW'(irq_out), 32'h0);
    rd(2'd0, 32'h0, "R1");
    rd(2'd1, 32'h0, "R1");
    rd(2'd2, 32'h0, "R1");
    rd(2'd3, 32'hFF, "R1");

    // R8 with the default period of 0xFF: 256 differing cycles needed
    req = "R8";
    wr(2'd2, 32'h1); wr(2'd1, 32'h1); wr(2'd0, 32'h1);
    clr(); irq_raw[0] = 1'b1;
    step(200);
    chk(lows[0] == 0, "R8", lows[0], 0);
    step(100);
    chk(lows[0] == 1, "R8", lows[0], 1);
    irq_raw[0] = 1'b0;
    step(300);

    // R2: register map and unimplemented bits
    req = "R2";
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h00FF_FFFF, "R2");
    wr(2'd3, 32'h0000_1234);
    rd(2'd3, 32'h34, "R2");
    wr(2'd1, 32'hA5A5_A5A5);
    rd(2'd1, 32'h00A5_A5A5, "R2");

    // working configuration, period 3
    wr(2'd3, 32'd3);
    wr(2'd0, (32'd1 << 0) | (32'd1 << 2) | (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 9) | (32'd1 << 23));
    wr(2'd1, (32'd1 << 0) | (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 12) | (32'd1 << 23));
    wr(2'd2, (32'd1 << 0) | (32'd1 << 5) | (32'd1 << 7) | (32'd1 << 12) | (32'd1 << 23));
    step(4);

    // R4: level latency on line 2
    req = "R4";
    irq_raw[2] = 1'b1;
    step(2);
    chk(irq_out[2] === 1'b0, "R4", irq_out[2], 0);
    step(1);
    chk(irq_out[2] === 1'b1, "R4", irq_out[2], 1);
    irq_raw[2] = 1'b0;
    step(4);
    chk(irq_out[2] === 1'b0, "R4", irq_out[2], 0);

    // R5: both edges of a long step give two pulses
    req = "R5";
    clr(); irq_raw[5] = 1'b1; step(12); irq_raw[5] = 1'b0; step(12);
    chk(lows[5] == 2, "R5", lows[5], 2);

    // R6: a 3-cycle excursion against period 3 is rejected
    req = "R6";
    clr(); irq_raw[5] = 1'b1; step(3); irq_raw[5] = 1'b0; step(12);
    chk(lows[5] == 0, "R6", lows[5], 0);

    // R7: both-edge line 9 without filter never pulses
    req = "R7";
    clr();
    for (int k = 0; k < 6; k++) begin irq_raw[9] = ~irq_raw[9]; step(8); end
    chk(lows[9] == 0, "R7", lows[9], 0);

    // R3: masked lines 12 (both-edge) and 14 (level) stay idle
    req = "R3";
    clr();
    for (int k = 0; k < 4; k++) begin irq_raw[12] = ~irq_raw[12]; irq_raw[14] = ~irq_raw[14]; step(10); end
    chk(lows[12] == 0, "R3", lows[12], 0);
    chk(highs[14] == 0, "R3", highs[14], 0);

    // R9: filter bit on a level line leaves a one-cycle pulse intact
    req = "R9";
    clr(); irq_raw[7] = 1'b1; step(1); irq_raw[7] = 1'b0; step(6);
    chk(highs[7] == 1, "R9", highs[7], 1);

    // R8: the shared period acts on lines 0 and 23 together
    req = "R8";
    clr(); irq_raw[0] = 1'b1; irq_raw[23] = 1'b1; step(6);
    irq_raw[0] = 1'b0; irq_raw[23] = 1'b0; step(12);
    chk(lows[0] == 2, "R8", lows[0], 2);
    chk(lows[23] == 2, "R8", lows[23], 2);
    wr(2'd3, 32'd8);
    clr(); irq_raw[0] = 1'b1; irq_raw[23] = 1'b1; step(6);
    irq_raw[0] = 1'b0; irq_raw[23] = 1'b0; step(12);
    chk(lows[0] == 0, "R8", lows[0], 0);
    chk(lows[23] == 0, "R8", lows[23], 0);

    // R5: sparse random toggles with stepping period, model compared per cycle
    req = "R5";
    wr(2'd2, 32'h00FF_F0F0);
    wr(2'd1, 32'h00F0_FF00);
    wr(2'd0, 32'h00FF_FF0F);
    for (int p = 0; p < 6; p++) begin
      wr(2'd3, p);
      for (int c = 0; c < 400; c++) begin
        irq_raw = irq_raw ^ NL'($urandom & $urandom & $urandom);
        step(1);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule